// File: doc/BRIEF.md
# Quad I/O Flash Fast-Read Controller

This block is a serial-flash master that fetches a run of bytes from a NOR flash using the quad-line fast-read sequence. A one-cycle `start` pulse latches a 24-bit byte address, an 8-bit mode value and a byte count. The block then pulls the chip select low and sends the 8-bit read command on line 0 alone. It widens to all four lines for the address and mode nibbles, releases the lines for four turnaround (dummy) clocks, and then collects one nibble per serial clock from the flash.

Each assembled byte appears on `rd_data` with a one-cycle `rd_valid` strobe. The consumer must take the byte in that cycle; there is no back-pressure. When the last requested byte has been received, the chip select returns high and `done` pulses. The serial clock runs at half the system clock rate with mode 0 timing: idle low, lines driven after the falling edge, input sampled on the rising edge. The four flash data lines are exposed as separate output, output-enable and input vectors, so the pad ring can build the tristate buffers.

Top module: `qspi_fastread`

## Requirements
- R1: After `start`, the first 8 serial clocks carry the command byte (default 8'hEB) on `io_out[0]`, most significant bit first, with `io_oe` equal to 4'b0001 and `spi_cs_n` low.
- R2: Serial clocks 9 to 16 carry {address[23:0], mode[7:0]} as 8 nibbles, most significant nibble first. In each cycle `io_out[3:0]` holds 4 bits, with bit 3 the most significant, so each byte goes out as bits 7..4 then bits 3..0. `io_oe` is 4'b1111 in these cycles.
- R3: Serial clocks 17 to 20 are dummy cycles. From the first dummy cycle until the chip select rises, `io_oe` is 4'b0000.
- R4: `spi_sck` is low whenever `spi_cs_n` is high. `io_out` and `io_oe` change only on the system clock edge that drives `spi_sck` low, never while `spi_sck` is high.
- R5: In the data phase, the block samples one nibble per serial-clock rising edge; the first nibble of each byte is bits 7..4. After the second nibble is sampled, the byte appears on `rd_data` with `rd_valid` high for exactly one cycle. Bytes arrive in flash order.
- R6: `spi_cs_n` stays low without a break from the first command bit to the end of the last data cycle, and the transaction spans exactly 20 + 2*N serial clocks for a byte count N.
- R7: `done` is a one-cycle pulse on the cycle `spi_cs_n` returns high, once per transaction, after all N bytes have been delivered.
- R8: A byte count of zero runs no data cycles: the chip select rises right after the fourth dummy cycle (20 serial clocks), `done` pulses, and no `rd_valid` appears.
- R9: A `start` pulse while a transaction is running is ignored: the address, mode, count and clock count of the running transaction are unchanged.
- R10: After reset, `spi_cs_n` is high, `spi_sck` is low, `io_oe` is 4'b0000, and `rd_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a read |
| addr | input | 24 | Flash byte address of the first byte |
| mode | input | 8 | Mode byte sent after the address |
| nbytes | input | CNT_W | Number of bytes to read |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | One-cycle strobe qualifying rd_data |
| done | output | 1 | One-cycle pulse at the end of the transaction |
| spi_cs_n | output | 1 | Active-low flash chip select |
| spi_sck | output | 1 | Serial clock, idle low |
| io_out | output | 4 | Values driven onto flash lines 3..0 |
| io_oe | output | 4 | Output enables for flash lines 3..0 |
| io_in | input | 4 | Values read from flash lines 3..0 |

## Verification
The bench models a flash that places a nibble on the lines after each falling serial clock. It targets the line-width switch from one line to four: a design that enabled all lines during the command, or enabled them one clock late, would fail the per-edge enable check. The address nibble order is also checked, because a design that sent low nibbles first or put the mode byte ahead of the address would send a wrong word. The turnaround is checked by confirming the enables drop at the first dummy clock and that exactly four dummy clocks pass; a design with an off-by-one dummy count would return every data byte shifted by a nibble. The zero-count case and a `start` arriving mid-transaction cover designs that would enter the data phase anyway or restart on the new request.

// File: rtl/qspi_rd_pkg.sv
package qspi_rd_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA
    } phase_e;

    localparam int CMD_CYC   = 8;
    localparam int ADDR_CYC  = 8;
    localparam int DUMMY_CYC = 4;
endpackage

// File: rtl/qspi_tx_mux.sv
module qspi_tx_mux
    import qspi_rd_pkg::*;
#(
    parameter logic [7:0] OPCODE = 8'hEB
) (
    input  phase_e     phase,
    input  logic [2:0] cnt,
    input  logic [3:0] nib,
    output logic [3:0] io_out,
    output logic [3:0] io_oe
);
    always_comb begin
        io_out = 4'b0000;
        io_oe  = 4'b0000;
        case (phase)
            PH_CMD: begin
                io_out[0] = OPCODE[3'd7 - cnt];
                io_oe     = 4'b0001;
            end
            PH_ADDR: begin
                io_out = nib;
                io_oe  = 4'b1111;
            end
            default: begin
                io_out = 4'b0000;
                io_oe  = 4'b0000;
            end
        endcase
    end
endmodule

// File: rtl/qspi_rx_nibble.sv
module qspi_rx_nibble (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample,
    input  logic       second,
    input  logic [3:0] io_in,
    output logic [7:0] rd_data,
    output logic       rd_valid
);
    typedef struct packed {
        logic [3:0] hi;
        logic [7:0] data;
        logic       valid;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        if (sample) begin
            if (second) begin
                rx_d.data  = {rx_q.hi, io_in};
                rx_d.valid = 1'b1;
            end else begin
                rx_d.hi = io_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign rd_data  = rx_q.data;
    assign rd_valid = rx_q.valid;
endmodule

// File: rtl/qspi_fastread.sv
module qspi_fastread
    import qspi_rd_pkg::*;
#(
    parameter int         CNT_W  = 8,
    parameter logic [7:0] OPCODE = 8'hEB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [23:0]      addr,
    input  logic [7:0]       mode,
    input  logic [CNT_W-1:0] nbytes,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             done,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic [3:0]       io_out,
    output logic [3:0]       io_oe,
    input  logic [3:0]       io_in
);
    localparam int SH_W = 32;
    localparam logic [2:0] CMD_LAST   = 3'(CMD_CYC - 1);
    localparam logic [2:0] ADDR_LAST  = 3'(ADDR_CYC - 1);
    localparam logic [2:0] DUMMY_LAST = 3'(DUMMY_CYC - 1);

    typedef struct packed {
        phase_e           phase;
        logic             sck;
        logic             cs_n;
        logic [2:0]       cnt;
        logic [SH_W-1:0]  sh;
        logic [CNT_W-1:0] left;
        logic             hi;
        logic             done;
    } st_t;

    st_t s_d, s_q;
    logic sample;
    logic second;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.phase == PH_IDLE) begin
            if (start) begin
                s_d.phase = PH_CMD;
                s_d.cs_n  = 1'b0;
                s_d.sck   = 1'b0;
                s_d.cnt   = '0;
                s_d.sh    = {addr, mode};
                s_d.left  = nbytes;
                s_d.hi    = 1'b1;
            end
        end else if (!s_q.sck) begin
            s_d.sck = 1'b1;
        end else begin
            s_d.sck = 1'b0;
            s_d.cnt = s_q.cnt + 3'd1;
            case (s_q.phase)
                PH_CMD: begin
                    if (s_q.cnt == CMD_LAST) begin
                        s_d.phase = PH_ADDR;
                        s_d.cnt   = '0;
                    end
                end
                PH_ADDR: begin
                    s_d.sh = s_q.sh << 4;
                    if (s_q.cnt == ADDR_LAST) begin
                        s_d.phase = PH_DUMMY;
                        s_d.cnt   = '0;
                    end
                end
                PH_DUMMY: begin
                    if (s_q.cnt == DUMMY_LAST) begin
                        s_d.cnt = '0;
                        s_d.hi  = 1'b1;
                        if (s_q.left == '0) begin
                            s_d.phase = PH_IDLE;
                            s_d.cs_n  = 1'b1;
                            s_d.done  = 1'b1;
                        end else begin
                            s_d.phase = PH_DATA;
                        end
                    end
                end
                PH_DATA: begin
                    s_d.cnt = '0;
                    s_d.hi  = !s_q.hi;
                    if (!s_q.hi) begin
                        s_d.left = s_q.left - 1'b1;
                        if (s_q.left == CNT_W'(1)) begin
                            s_d.phase = PH_IDLE;
                            s_d.cs_n  = 1'b1;
                            s_d.done  = 1'b1;
                        end
                    end
                end
                default: s_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
            s_q.cs_n  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sample = (s_q.phase == PH_DATA) && !s_q.sck;
    assign second = !s_q.hi;

    qspi_tx_mux #(.OPCODE(OPCODE)) u_tx (
        .phase  (s_q.phase),
        .cnt    (s_q.cnt),
        .nib    (s_q.sh[SH_W-1 -: 4]),
        .io_out (io_out),
        .io_oe  (io_oe)
    );

    qspi_rx_nibble u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (sample),
        .second   (second),
        .io_in    (io_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign spi_cs_n = s_q.cs_n;
    assign spi_sck  = s_q.sck;
    assign done     = s_q.done;
endmodule

// File: rtl/qspi_fastread_chk.sv
module qspi_fastread_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] nbytes,
    input logic             rd_valid,
    input logic             done,
    input logic             spi_cs_n,
    input logic             spi_sck,
    input logic [3:0]       io_out,
    input logic [3:0]       io_oe
);
    // R2/R3: only the three legal enable patterns ever appear
    a_r2_oe_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b1111));

    // R3: lines released whenever the flash is deselected
    a_r3_released_idle: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (io_oe == 4'b0000));

    // R4: clock idles low
    a_r4_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R4: lines hold across the rising edge
    a_r4_stable_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sck) |-> ($stable(io_out) && $stable(io_oe)));

    // R5: byte strobe lasts a single cycle
    a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R7: done coincides with chip select release
    a_r7_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> done);

    // R7: done is a pulse while deselected
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (spi_cs_n ##1 !done));

    // R8: no strobe once deselected for more than a cycle
    a_r8_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && !done) |-> !rd_valid);

    // R9: a start during a transaction keeps the chip select low
    a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !spi_cs_n && !done) |=> !spi_cs_n || done);
endmodule

bind qspi_fastread qspi_fastread_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .nbytes   (nbytes),
    .rd_valid (rd_valid),
    .done     (done),
    .spi_cs_n (spi_cs_n),
    .spi_sck  (spi_sck),
    .io_out   (io_out),
    .io_oe    (io_oe)
);

// File: tb/qspi_fastread_test.sv
module qspi_fastread_test;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [23:0]      addr = '0;
    logic [7:0]       mode = '0;
    logic [CNT_W-1:0] nbytes = '0;
    logic [7:0]       rd_data;
    logic             rd_valid;
    logic             done;
    logic             spi_cs_n;
    logic             spi_sck;
    logic [3:0]       io_out;
    logic [3:0]       io_oe;
    logic [3:0]       io_in = '0;

    always #4 clk = !clk;

    qspi_fastread #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .mode(mode),
        .nbytes(nbytes), .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .io_out(io_out),
        .io_oe(io_oe), .io_in(io_in)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // {addr, mode, count}
    localparam logic [39:0] VEC [4] = '{
        {24'h123456, 8'hA5, 8'd3},
        {24'hFFFFFF, 8'h00, 8'd1},
        {24'h000000, 8'hFF, 8'd0},
        {24'hC3A50F, 8'h5A, 8'd6}
    };

    logic [23:0] cur_addr = '0;
    int          rises = 0;
    logic [7:0]  cap_op;
    logic [31:0] cap_am;
    int          oe_err = 0;
    int          cs_err = 0;
    int          r4_err = 0;
    int          nb_got = 0;
    int          done_cnt = 0;
    int          data_bad = 0;
    logic        prev_sck = 1'b0;
    logic [3:0]  prev_out = '0;
    logic [3:0]  prev_oe = '0;

    function automatic logic [7:0] pat(input logic [23:0] a, input int b);
        return (a[7:0] ^ 8'h3C) + 8'(b * 29);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // flash line monitor at each rising serial clock
    always @(posedge spi_sck) begin
        if (spi_cs_n) cs_err++;
        if (rises < 8) begin
            cap_op = {cap_op[6:0], io_out[0]};
            if (io_oe != 4'b0001) oe_err++;
        end else if (rises < 16) begin
            cap_am = {cap_am[27:0], io_out};
            if (io_oe != 4'b1111) oe_err++;
        end else begin
            if (io_oe != 4'b0000) oe_err++;
        end
        rises++;
    end

    // flash model: next nibble after each falling serial clock
    always @(negedge spi_sck) begin
        if (rises >= 20) begin
            automatic int i = rises - 20;
            automatic logic [7:0] bv = pat(cur_addr, i / 2);
            io_in <= #1 ((i % 2) == 0) ? bv[7:4] : bv[3:0];
        end
    end

    // byte, done and timing monitor
    always @(negedge clk) begin
        cyc++;
        if (rd_valid) begin
            if (rd_data != pat(cur_addr, nb_got)) begin
                data_bad++;
                $display("FAIL R5 byte %0d actual=%0h expected=%0h", nb_got,
                         rd_data, pat(cur_addr, nb_got));
            end
            nb_got++;
        end
        if (done) done_cnt++;
        if (rst_n) begin
            if (prev_sck && spi_sck && (io_out != prev_out || io_oe != prev_oe)) r4_err++;
            if (spi_cs_n && spi_sck) r4_err++;
        end
        prev_sck = spi_sck;
        prev_out = io_out;
        prev_oe  = io_oe;
    end

    task automatic clear_mon();
        rises = 0; cap_op = '0; cap_am = '0; oe_err = 0; cs_err = 0;
        r4_err = 0; nb_got = 0; done_cnt = 0; data_bad = 0;
    endtask

    task automatic pulse_start(input logic [23:0] a, input logic [7:0] m,
                               input logic [7:0] n);
        @(negedge clk);
        addr = a; mode = m; nbytes = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 600; k++) begin
            if (done_cnt > 0) break;
            @(negedge clk);
        end
        if (done_cnt == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R7 timeout actual=0 expected=1");
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic check_txn(input logic [23:0] a, input logic [7:0] m,
                             input int n);
        check(cap_op == 8'hEB, "R1 opcode", 64'(cap_op), 64'hEB);
        check(cap_am == {a, m}, "R2 address/mode", 64'(cap_am), 64'({a, m}));
        check(oe_err == 0, "R3 enables", 64'(oe_err), 64'd0);
        check(r4_err == 0, "R4 edge timing", 64'(r4_err), 64'd0);
        check(nb_got == n && data_bad == 0, "R5 bytes", 64'(nb_got), 64'(n));
        check(rises == 20 + 2 * n && cs_err == 0, "R6 clock count",
              64'(rises), 64'(20 + 2 * n));
        check(done_cnt == 1 && spi_cs_n, "R7 done", 64'(done_cnt), 64'd1);
    endtask

    always @(posedge clk) begin
        if (cyc >= 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R10 cs/sck",
              64'({spi_cs_n, spi_sck}), 64'b10);
        check(io_oe == 4'b0000 && !rd_valid && !done, "R10 oe/valid/done",
              64'({io_oe, rd_valid, done}), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < 4; v++) begin
            automatic logic [23:0] a = VEC[v][39:16];
            automatic logic [7:0]  m = VEC[v][15:8];
            automatic logic [7:0]  n = VEC[v][7:0];
            clear_mon();
            cur_addr = a;
            pulse_start(a, m, n);
            wait_done();
            check_txn(a, m, int'(n));
        end

        // R8 zero-length read: no data cycles, no strobes
        clear_mon();
        cur_addr = 24'h0A0B0C;
        pulse_start(24'h0A0B0C, 8'h11, 8'd0);
        wait_done();
        check(rises == 20, "R8 clocks", 64'(rises), 64'd20);
        check(nb_got == 0 && done_cnt == 1, "R8 no bytes", 64'(nb_got), 64'd0);

        // R9 start during a transaction is ignored
        clear_mon();
        cur_addr = 24'h456789;
        pulse_start(24'h456789, 8'h3E, 8'd2);
        repeat (30) @(negedge clk);
        pulse_start(24'h999999, 8'h77, 8'd9);
        wait_done();
        check(cap_am == {24'h456789, 8'h3E}, "R9 address kept", 64'(cap_am),
              64'({24'h456789, 8'h3E}));
        check(rises == 24 && nb_got == 2, "R9 count kept", 64'(rises), 64'd24);

        // R10 mid-transaction reset returns to idle
        clear_mon();
        pulse_start(24'h010203, 8'h00, 8'd4);
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(spi_cs_n && !spi_sck && io_oe == 4'b0000, "R10 reset mid-read",
              64'({spi_cs_n, spi_sck, io_oe}), 64'b100000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule